// File: doc/BRIEF.md
# Requester-ID to Stream-ID Translation Table

This block turns the 16-bit bus/device/function requester ID carried by an incoming transaction into a 6-bit stream ID. The interrupt translation path and the IOMMU both use that stream ID, so one table serves both. Each lookup also returns a 3-bit auxiliary ID.

The table has 32 entries. Each entry stores a valid flag, a requester ID, a 16-bit compare mask, a stream ID and an auxiliary ID. Software never reaches an entry directly. It goes through a three-word indirect window: one control word and two staging words. Writing the control word with an index either copies that entry into the staging words, where software can read it, or writes the staging words into that entry. A bit in the control word picks which of the two happens.

The lookup port runs beside the window and compares the incoming requester ID against every entry in parallel. When several entries match, the one with the lowest index wins. The result is registered.

Top module: `rid_sid_lut`

## Requirements
- R1: After reset, every entry is invalid with all fields zero, every window word reads zero, and every lookup misses.
- R2: Window word address 0 is the control word. Bits [4:0] hold the entry index and bit 16 is the fetch flag. A read returns the last written index and flag, with every other bit zero.
- R3: Writing the control word with bit 16 set copies the indexed entry into staging words 1 and 2.
- R4: Writing the control word with bit 16 clear writes the staging words into the indexed entry. A lookup presented in the cycle right after that write already sees the new contents.
- R5: Staging word 1 is at address 1. Its fields are stream ID in bits [5:0], auxiliary ID in bits [10:8] and valid in bit 31. All other bits read zero, and the word holds its value when it is not written.
- R6: Staging word 2 is at address 2. It holds the requester ID in bits [31:16] and the mask in bits [15:0].
- R7: An entry matches when it is valid and the incoming ID equals the stored ID on every bit where the mask is 1. An all-ones mask demands an exact match, and an all-zero mask matches any ID.
- R8: When several valid entries match, the lowest-index entry supplies the stream and auxiliary IDs.
- R9: On a miss, the hit flag is 0 and the stream and auxiliary outputs are both 0.
- R10: A lookup result appears at the outputs after the first rising clock edge following the presentation of the requester ID.
- R11: Writing zero to both staging words and committing them at an index invalidates that entry, so it no longer matches.
- R12: Read data appears one clock edge after the address is presented. Address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | 2 | Window word address |
| cfg_we | input | 1 | Write enable for the window |
| cfg_wdata | input | 32 | Window write data |
| cfg_rdata | output | 32 | Window read data, registered |
| lk_rid | input | 16 | Requester ID to translate |
| lk_hit | output | 1 | Lookup matched a valid entry |
| lk_sid | output | 6 | Stream ID of the winning entry |
| lk_aux | output | 3 | Auxiliary ID of the winning entry |

## Verification
Both result paths sit one register after their inputs. Window read data and lookup outputs therefore change only at the rising edge that follows the address or requester ID being applied. The bench drives inputs on the falling edge and samples one falling edge later. For the two latency requirements, it also samples just after driving, to confirm that the previous value is still on the output. Committing an entry and looking it up are placed on back-to-back cycles. This shows that a fresh entry can be used at once.

// File: rtl/rid_lut_pkg.sv
package rid_lut_pkg;
   localparam int RID_W       = 16;
   localparam int SID_W       = 6;
   localparam int AUX_W       = 3;
   localparam int IDX_FIELD_W = 5;
   localparam int WIN_AW      = 2;

   // bit positions software decodes
   localparam int ACC_FETCH_BIT = 16;
   localparam int D1_VLD_BIT    = 31;
   localparam int D1_AUX_LSB    = 8;
   localparam int D1_SID_LSB    = 0;
   localparam int D2_RID_LSB    = 16;
   localparam int D2_MSK_LSB    = 0;

   localparam logic [WIN_AW-1:0] WIN_ACC  = 2'd0;
   localparam logic [WIN_AW-1:0] WIN_DAT1 = 2'd1;
   localparam logic [WIN_AW-1:0] WIN_DAT2 = 2'd2;

   typedef struct packed {
      logic             vld;
      logic [AUX_W-1:0] aux;
      logic [SID_W-1:0] sid;
      logic [RID_W-1:0] rid;
      logic [RID_W-1:0] msk;
   } lut_entry_t;
endpackage

// File: rtl/rid_lut_window.sv
module rid_lut_window
   import rid_lut_pkg::*;
#(
   parameter int ENTRIES = 32,
   parameter int DATA_W  = 32,
   localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [WIN_AW-1:0]       cfg_addr,
   input  logic                    cfg_we,
   input  logic [DATA_W-1:0]       cfg_wdata,
   output logic [DATA_W-1:0]       cfg_rdata,
   output lut_entry_t [ENTRIES-1:0] ent_o
);
   lut_entry_t [ENTRIES-1:0] ent_q;
   lut_entry_t               staged;
   logic [IDX_FIELD_W-1:0]   acc_idx_q;
   logic                     acc_fetch_q;
   logic                     d1_vld_q;
   logic [AUX_W-1:0]         d1_aux_q;
   logic [SID_W-1:0]         d1_sid_q;
   logic [RID_W-1:0]         d2_rid_q;
   logic [RID_W-1:0]         d2_msk_q;
   logic [DATA_W-1:0]        rd_word;

   logic [IDX_FIELD_W-1:0]   wr_idx;
   logic [IDX_W-1:0]         wr_sel;
   logic                     idx_ok;
   logic                     wr_acc, fetch, commit;
   logic                     unused_wbits;

   assign unused_wbits = ^cfg_wdata;
   assign wr_idx = cfg_wdata[IDX_FIELD_W-1:0];
   assign wr_sel = wr_idx[IDX_W-1:0];

   // only a table smaller than the index field needs a range check
   generate
      if (ENTRIES < (1 << IDX_FIELD_W)) begin : g_idx_chk
         assign idx_ok = (int'(wr_idx) < ENTRIES);
      end else begin : g_idx_full
         assign idx_ok = 1'b1;
      end
   endgenerate

   assign wr_acc = cfg_we && (cfg_addr == WIN_ACC);
   assign fetch  = wr_acc &&  cfg_wdata[ACC_FETCH_BIT] && idx_ok;
   assign commit = wr_acc && !cfg_wdata[ACC_FETCH_BIT] && idx_ok;

   always_comb begin
      staged     = '0;
      staged.vld = d1_vld_q;
      staged.aux = d1_aux_q;
      staged.sid = d1_sid_q;
      staged.rid = d2_rid_q;
      staged.msk = d2_msk_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) ent_q[i] <= '0;
      end else if (commit) begin
         ent_q[wr_sel] <= staged;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_idx_q   <= '0;
         acc_fetch_q <= 1'b0;
      end else if (wr_acc) begin
         acc_idx_q   <= wr_idx;
         acc_fetch_q <= cfg_wdata[ACC_FETCH_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         d1_vld_q <= 1'b0;
         d1_aux_q <= '0;
         d1_sid_q <= '0;
         d2_rid_q <= '0;
         d2_msk_q <= '0;
      end else if (fetch) begin
         d1_vld_q <= ent_q[wr_sel].vld;
         d1_aux_q <= ent_q[wr_sel].aux;
         d1_sid_q <= ent_q[wr_sel].sid;
         d2_rid_q <= ent_q[wr_sel].rid;
         d2_msk_q <= ent_q[wr_sel].msk;
      end else if (cfg_we && cfg_addr == WIN_DAT1) begin
         d1_vld_q <= cfg_wdata[D1_VLD_BIT];
         d1_aux_q <= cfg_wdata[D1_AUX_LSB +: AUX_W];
         d1_sid_q <= cfg_wdata[D1_SID_LSB +: SID_W];
      end else if (cfg_we && cfg_addr == WIN_DAT2) begin
         d2_rid_q <= cfg_wdata[D2_RID_LSB +: RID_W];
         d2_msk_q <= cfg_wdata[D2_MSK_LSB +: RID_W];
      end
   end

   always_comb begin
      rd_word = '0;
      case (cfg_addr)
         WIN_ACC: begin
            rd_word[IDX_FIELD_W-1:0] = acc_idx_q;
            rd_word[ACC_FETCH_BIT]   = acc_fetch_q;
         end
         WIN_DAT1: begin
            rd_word[D1_VLD_BIT]              = d1_vld_q;
            rd_word[D1_AUX_LSB +: AUX_W]     = d1_aux_q;
            rd_word[D1_SID_LSB +: SID_W]     = d1_sid_q;
         end
         WIN_DAT2: begin
            rd_word[D2_RID_LSB +: RID_W]     = d2_rid_q;
            rd_word[D2_MSK_LSB +: RID_W]     = d2_msk_q;
         end
         default: rd_word = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_rdata <= '0;
      else        cfg_rdata <= rd_word;
   end

   assign ent_o = ent_q;

   // R4
   commit_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> ent_q[$past(wr_sel)] == $past(staged));

   // R3
   fetch_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fetch |=> (d1_sid_q == $past(ent_q[wr_sel].sid)) &&
                (d1_vld_q == $past(ent_q[wr_sel].vld)) &&
                (d2_rid_q == $past(ent_q[wr_sel].rid)));

   // R5
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> $stable(d1_sid_q) && $stable(d1_vld_q) && $stable(d2_rid_q) &&
                  $stable(d2_msk_q) && $stable(acc_idx_q));
endmodule

// File: rtl/rid_lut_match.sv
module rid_lut_match
   import rid_lut_pkg::*;
#(
   parameter int ENTRIES = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  lut_entry_t [ENTRIES-1:0] ent_i,
   input  logic [RID_W-1:0]         lk_rid,
   output logic                     hit_q,
   output logic [SID_W-1:0]         sid_q,
   output logic [AUX_W-1:0]         aux_q
);
   logic [ENTRIES-1:0] hv;
   logic [ENTRIES-1:0] vld_vec;
   logic               hit_d;
   logic [SID_W-1:0]   sid_d;
   logic [AUX_W-1:0]   aux_d;

   generate
      for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
         assign vld_vec[g] = ent_i[g].vld;
         assign hv[g] = ent_i[g].vld &&
                        (((lk_rid ^ ent_i[g].rid) & ent_i[g].msk) == '0);
      end
   endgenerate

   // walk from the top so the lowest matching index is written last
   always_comb begin
      hit_d = 1'b0;
      sid_d = '0;
      aux_d = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (hv[i]) begin
            hit_d = 1'b1;
            sid_d = ent_i[i].sid;
            aux_d = ent_i[i].aux;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_q <= 1'b0;
         sid_q <= '0;
         aux_q <= '0;
      end else begin
         hit_q <= hit_d;
         sid_q <= sid_d;
         aux_q <= aux_d;
      end
   end

   // R9
   empty_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_vec == '0) |=> !hit_q && (sid_q == '0));

   // R10
   follow_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hv != '0) |=> hit_q);
endmodule

// File: rtl/rid_sid_lut.sv
module rid_sid_lut
   import rid_lut_pkg::*;
#(
   parameter int ENTRIES = 32,
   parameter int DATA_W  = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          cfg_addr,
   input  logic                cfg_we,
   input  logic [DATA_W-1:0]   cfg_wdata,
   output logic [DATA_W-1:0]   cfg_rdata,
   input  logic [15:0]         lk_rid,
   output logic                lk_hit,
   output logic [5:0]          lk_sid,
   output logic [2:0]          lk_aux
);
   generate
      if (ENTRIES < 1 || ENTRIES > (1 << IDX_FIELD_W)) begin : g_bad_depth
         $error("ENTRIES must lie between 1 and the index field range");
      end
      if (DATA_W != 32) begin : g_bad_width
         $error("window words must be 32 bits wide");
      end
   endgenerate

   lut_entry_t [ENTRIES-1:0] ent;

   rid_lut_window #(.ENTRIES(ENTRIES), .DATA_W(DATA_W)) u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_addr (cfg_addr),
      .cfg_we   (cfg_we),
      .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata),
      .ent_o    (ent)
   );

   rid_lut_match #(.ENTRIES(ENTRIES)) u_match (
      .clk   (clk),
      .rst_n (rst_n),
      .ent_i (ent),
      .lk_rid(lk_rid),
      .hit_q (lk_hit),
      .sid_q (lk_sid),
      .aux_q (lk_aux)
   );
endmodule

// File: tb/sim_rid_sid_lut.sv
`timescale 1ns/100ps
module sim_rid_sid_lut;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cfg_addr = '0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic [15:0] lk_rid = '0;
   logic        lk_hit;
   logic [5:0]  lk_sid;
   logic [2:0]  lk_aux;
   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   rid_sid_lut u0 (
      .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_we(cfg_we),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lk_rid(lk_rid),
      .lk_hit(lk_hit), .lk_sid(lk_sid), .lk_aux(lk_aux)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h exp %h", tag, got, exp);
      end
   endtask

   // all tasks start and end on a falling edge
   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      cfg_addr = a; cfg_we = 1'b1; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      cfg_addr = a; cfg_we = 1'b0;
      @(negedge clk);
      d = cfg_rdata;
   endtask

   task automatic prog(input int idx, input logic v, input logic [2:0] aux,
                       input logic [5:0] sid, input logic [15:0] rid, input logic [15:0] msk);
      wr(2'd1, {v, 20'd0, aux, 2'd0, sid});
      wr(2'd2, {rid, msk});
      wr(2'd0, 32'(idx));
   endtask

   task automatic kill(input int idx);
      prog(idx, 1'b0, 3'd0, 6'd0, 16'd0, 16'd0);
   endtask

   task automatic look(input string tag, input logic [15:0] rid, input logic h,
                       input logic [5:0] s, input logic [2:0] x);
      lk_rid = rid;
      @(negedge clk);
      chk(tag, {22'd0, lk_hit, lk_sid, lk_aux}, {22'd0, h, s, x});
   endtask

   task automatic t_reset;
      logic [31:0] d;
      rd(2'd0, d); chk("R1 acc", d, 32'h0);
      rd(2'd1, d); chk("R1 d1", d, 32'h0);
      rd(2'd2, d); chk("R1 d2", d, 32'h0);
      look("R1 miss", 16'h0000, 1'b0, 6'd0, 3'd0);
      wr(2'd0, 32'h0001_0011);
      rd(2'd2, d); chk("R1 entry17", d, 32'h0);
   endtask

   task automatic t_fields;
      logic [31:0] d;
      wr(2'd0, 32'hFFFF_FFFF);
      rd(2'd0, d); chk("R2 acc", d, 32'h0001_001F);
      wr(2'd1, 32'hFFFF_FFFF);
      rd(2'd1, d); chk("R5 d1", d, 32'h8000_073F);
      wr(2'd2, 32'hDEAD_BEEF);
      rd(2'd2, d); chk("R6 d2", d, 32'hDEAD_BEEF);
      rd(2'd3, d); chk("R12 hole", d, 32'h0);
      wr(2'd0, 32'h4);
      look("R4 window commit", 16'hDEAD, 1'b1, 6'd63, 3'd7);
      kill(4);
      look("R11 window kill", 16'hDEAD, 1'b0, 6'd0, 3'd0);
   endtask

   task automatic t_fetch;
      logic [31:0] d;
      prog(9, 1'b1, 3'd5, 6'd21, 16'hA5A5, 16'h0F0F);
      wr(2'd1, 32'h0);
      wr(2'd2, 32'h1234_5678);
      wr(2'd0, 32'h0001_0009);
      rd(2'd1, d); chk("R3 d1", d, 32'h8000_0515);
      rd(2'd2, d); chk("R3 d2", d, 32'hA5A5_0F0F);
      kill(9);
   endtask

   task automatic t_fill;
      for (int i = 0; i < 32; i++)
         prog(i, 1'b1, 3'(i % 8), 6'(63 - i), 16'(16'h0100 + i), 16'hFFFF);
      for (int i = 0; i < 32; i++)
         look("R7 exact", 16'(16'h0100 + i), 1'b1, 6'(63 - i), 3'(i % 8));
      look("R7 exact off", 16'h0120, 1'b0, 6'd0, 3'd0);
      for (int i = 0; i < 32; i++) kill(i);
      look("R11 all gone", 16'h0100, 1'b0, 6'd0, 3'd0);
   endtask

   task automatic t_mask;
      prog(2, 1'b1, 3'd2, 6'd11, 16'h1230, 16'hFFF0);
      look("R7 masked low", 16'h123F, 1'b1, 6'd11, 3'd2);
      look("R7 masked high", 16'h1330, 1'b0, 6'd0, 3'd0);
      kill(2);
   endtask

   task automatic t_priority;
      prog(7, 1'b1, 3'd1, 6'd9, 16'h1234, 16'hFFFF);
      prog(30, 1'b1, 3'd6, 6'd40, 16'h0000, 16'h0000);
      prog(3, 1'b1, 3'd3, 6'd5, 16'h1200, 16'hFF00);
      look("R8 lowest", 16'h1234, 1'b1, 6'd5, 3'd3);
      look("R7 catch all", 16'h5555, 1'b1, 6'd40, 3'd6);
      kill(3);
      look("R11 next wins", 16'h1234, 1'b1, 6'd9, 3'd1);
      kill(30);
      look("R9 miss zero", 16'h5555, 1'b0, 6'd0, 3'd0);
      kill(7);
   endtask

   task automatic t_timing;
      logic [31:0] d;
      look("R10 pre", 16'h7777, 1'b0, 6'd0, 3'd0);
      prog(12, 1'b1, 3'd4, 6'd33, 16'h7777, 16'hFFFF);
      lk_rid = 16'h7777;
      #1 chk("R10 not yet", {31'd0, lk_hit}, 32'd0);
      @(negedge clk);
      chk("R4 next cycle", {26'd0, lk_sid}, 32'd33);
      chk("R10 hit", {31'd0, lk_hit}, 32'd1);
      wr(2'd0, 32'h0001_000C);
      rd(2'd0, d);
      cfg_addr = 2'd1;
      #1 chk("R12 old data", cfg_rdata, 32'h0001_000C);
      @(negedge clk);
      chk("R12 new data", cfg_rdata, 32'h8000_0421);
      kill(12);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_fields;
      t_fetch;
      t_fill;
      t_mask;
      t_priority;
      t_timing;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule